// File: doc/BRIEF.md
# Switching-Frequency Dither Sequencer

This block lowers the peak of conducted switching noise by varying the converter's switching period in a fixed cycle of five frequency multipliers. The loop goes ×0.9, ×1.1, ×1.05, ×1.0, ×0.95 and then repeats. The block takes a base-rate select (50 kHz or 70 kHz), a run enable from the protection logic, and a single-cycle pulse at each switching-period boundary. It returns the length of the next switching period, counted in system-clock cycles, together with the current stage index.

Each stage is held for a set number of switching periods before the next stage starts. When the run enable is low, the sequence goes back to its first stage. A new base-rate select is applied only at a stage boundary, so no period within a stage comes from a mix of the two bases. All ten period values are worked out at elaboration from the clock rate and the two base rates, rounded to the nearest clock cycle.

Top module: `freq_dither_seq`

## Requirements
- R1: After a synchronous reset, `stage_idx` is 0 and `period_cycles` is the ×0.9 period for the base that `base_hi` selects at reset.
- R2: Stage index encoding is 0=×0.9, 1=×1.1, 2=×1.05, 3=×1.0, 4=×0.95. With a 100 MHz clock and `base_hi`=0 (50 kHz), `period_cycles` is 2222, 1818, 1905, 2000 and 2105 for stages 0 to 4.
- R3: With `base_hi`=1 (70 kHz), `period_cycles` is 1587, 1299, 1361, 1429 and 1504 for stages 0 to 4.
- R4: While `run_en` is high, each `period_tick` counts one period. After `dwell_len` counted periods the stage advances by one, and the new stage appears on the cycle after the tick that completed the dwell.
- R5: Stage 4 is followed by stage 0, and the loop repeats without end.
- R6: A `dwell_len` of 0 gives a dwell of 16 periods.
- R7: On the cycle after `run_en` is seen low, `stage_idx` is 0 and the period count is cleared. While `run_en` is low, ticks have no effect.
- R8: A change of `base_hi` has no effect on `period_cycles` in the middle of a stage. It is taken up when the stage advances (the value present on the tick that completes the dwell) or while `run_en` is low.
- R9: With no tick and no change of `run_en`, `stage_idx` and `period_cycles` hold their values.
- R10: If a tick arrives on the same cycle that `run_en` is low, the disable wins: the stage goes to 0 and does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Switching allowed (from the protection logic) |
| base_hi | input | 1 | Base-rate select: 0 = 50 kHz, 1 = 70 kHz |
| period_tick | input | 1 | One-cycle pulse at each switching-period boundary |
| dwell_len | input | DWELL_W | Periods per stage; 0 gives the default of 16 |
| period_cycles | output | PERIOD_W | Length of the next switching period in clock cycles |
| stage_idx | output | 3 | Current multiplier stage, 0..4 |

## Verification
Two events can land on the same cycle. The first is a period tick that ends a dwell arriving together with a change of the base select. The second is a tick arriving on a cycle where the run enable is low. The bench forces each case by driving both inputs on the same falling edge. In the first case it checks that the new stage uses the new base at once. In the second it checks that the stage returns to 0 rather than moving forward, and that a later re-enable starts counting from zero.

// File: rtl/freq_dither_pkg.sv
// Package: freq_dither_pkg
// Shared constants, the stage type, and the elaboration-time period
// arithmetic for the frequency dither sequencer.
// Assumes: multipliers are expressed as integers over a common
// denominator of 20 so that all arithmetic stays in integers.
package freq_dither_pkg;

    localparam int NUM_STAGES = 5;
    localparam int STAGE_W    = 3;
    localparam int MULT_DEN   = 20;

    typedef logic [STAGE_W-1:0] stage_t;

    // Multiplier numerator over MULT_DEN for each stage, in loop order.
    function automatic longint unsigned mult_num(input int idx);
        case (idx)
            0:       return 64'd18;   // x0.90
            1:       return 64'd22;   // x1.10
            2:       return 64'd21;   // x1.05
            3:       return 64'd20;   // x1.00
            4:       return 64'd19;   // x0.95
            default: return 64'd20;
        endcase
    endfunction

    // Nearest-integer clock count of one period at base*multiplier.
    function automatic longint unsigned period_of(
        input longint unsigned clk_hz,
        input longint unsigned base_hz,
        input int              idx
    );
        longint unsigned numer;
        longint unsigned denom;
        numer = clk_hz * longint'(MULT_DEN);
        denom = base_hz * mult_num(idx);
        return (2 * numer + denom) / (2 * denom);
    endfunction

endpackage

// File: rtl/freq_dither_period_lut.sv
// Module: freq_dither_period_lut
// Constant table of the five dithered periods for one base rate,
// indexed by stage. Contents are fixed at elaboration.
// Assumes: every period fits in PERIOD_W bits; out-of-range stage
// indices return the stage-0 period.
module freq_dither_period_lut
    import freq_dither_pkg::*;
#(
    parameter longint unsigned CLK_HZ   = 100_000_000,
    parameter longint unsigned BASE_HZ  = 50_000,
    parameter int              PERIOD_W = 16
) (
    input  stage_t              stage,
    output logic [PERIOD_W-1:0] period
);

    logic [PERIOD_W-1:0] table_q [NUM_STAGES];

    // One constant entry per stage.
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_entry
        localparam longint unsigned ENTRY = period_of(CLK_HZ, BASE_HZ, g);
        assign table_q[g] = PERIOD_W'(ENTRY);
    end

    // Stage-indexed read with a safe default.
    always_comb begin
        period = table_q[0];
        for (int i = 0; i < NUM_STAGES; i++) begin
            if (stage == stage_t'(i)) begin
                period = table_q[i];
            end
        end
    end

endmodule

// File: rtl/freq_dither_dwell_ctr.sv
// Module: freq_dither_dwell_ctr
// Counts period ticks within a stage and flags the tick that completes
// the dwell. A dwell setting of zero selects DEFAULT_DWELL.
// Assumes: period_tick is a one-cycle pulse; a lowered dwell setting
// in mid-stage ends the stage on the next tick.
module freq_dither_dwell_ctr #(
    parameter int DWELL_W       = 8,
    parameter int DEFAULT_DWELL = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               period_tick,
    input  logic [DWELL_W-1:0] dwell_len,
    output logic [DWELL_W-1:0] tick_cnt,
    output logic               stage_done
);

    localparam logic [DWELL_W-1:0] DWELL_DEF = DWELL_W'(DEFAULT_DWELL);

    logic [DWELL_W-1:0] dwell_eff;
    logic [DWELL_W-1:0] dwell_last;

    // Effective dwell length, mapping zero onto the default.
    always_comb begin
        dwell_eff  = (dwell_len == '0) ? DWELL_DEF : dwell_len;
        dwell_last = dwell_eff - DWELL_W'(1);
    end

    // Completion flag for the counted tick that ends a stage.
    always_comb begin
        stage_done = run_en && period_tick && (tick_cnt >= dwell_last);
    end

    // Tick counter: cleared on reset, on disable and at stage end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            tick_cnt <= '0;
        end else if (period_tick) begin
            if (stage_done) begin
                tick_cnt <= '0;
            end else begin
                tick_cnt <= tick_cnt + DWELL_W'(1);
            end
        end
    end

endmodule

// File: rtl/freq_dither_stage_fsm.sv
// Module: freq_dither_stage_fsm
// Holds the current multiplier stage and the latched base select.
// The stage moves one step on stage_done and wraps after the last
// stage. The base select is latched only at a stage step or while
// disabled.
// Assumes: stage_done is only ever high while run_en is high.
module freq_dither_stage_fsm
    import freq_dither_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_en,
    input  logic   stage_done,
    input  logic   base_hi,
    output stage_t stage_q,
    output logic   base_hi_q
);

    localparam stage_t STAGE_LAST = stage_t'(NUM_STAGES - 1);

    stage_t stage_next;

    // Next stage in the loop, wrapping after the last one.
    always_comb begin
        stage_next = (stage_q == STAGE_LAST) ? '0 : stage_q + stage_t'(1);
    end

    // Stage register: restarts at the first stage when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            stage_q <= '0;
        end else if (stage_done) begin
            stage_q <= stage_next;
        end
    end

    // Base-select latch: follows the input only at stage steps or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en || stage_done) begin
            base_hi_q <= base_hi;
        end
    end

endmodule

// File: rtl/freq_dither_seq.sv
// Module: freq_dither_seq (top)
// Frequency dither sequencer: steps the switching period through five
// multipliers, holding each for a set number of periods, and gives
// out the next period length in clock cycles for the selected base.
// Assumes: CLK_HZ is the clock driving clk; period_tick comes from
// the switching-period timer; run_en is the protection-cleared enable.
module freq_dither_seq
    import freq_dither_pkg::*;
#(
    parameter longint unsigned CLK_HZ        = 100_000_000,
    parameter longint unsigned BASE_LO_HZ    = 50_000,
    parameter longint unsigned BASE_HI_HZ    = 70_000,
    parameter int              PERIOD_W      = 16,
    parameter int              DWELL_W       = 8,
    parameter int              DEFAULT_DWELL = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic                base_hi,
    input  logic                period_tick,
    input  logic [DWELL_W-1:0]  dwell_len,
    output logic [PERIOD_W-1:0] period_cycles,
    output logic [2:0]          stage_idx
);

    logic [DWELL_W-1:0]  tick_cnt;
    logic                stage_done;
    stage_t              stage_q;
    logic                base_hi_q;
    logic [PERIOD_W-1:0] period_lo;
    logic [PERIOD_W-1:0] period_hi;

    freq_dither_dwell_ctr #(
        .DWELL_W       (DWELL_W),
        .DEFAULT_DWELL (DEFAULT_DWELL)
    ) dwell_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .period_tick (period_tick),
        .dwell_len   (dwell_len),
        .tick_cnt    (tick_cnt),
        .stage_done  (stage_done)
    );

    freq_dither_stage_fsm stage_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .stage_done (stage_done),
        .base_hi    (base_hi),
        .stage_q    (stage_q),
        .base_hi_q  (base_hi_q)
    );

    freq_dither_period_lut #(
        .CLK_HZ   (CLK_HZ),
        .BASE_HZ  (BASE_LO_HZ),
        .PERIOD_W (PERIOD_W)
    ) lut_lo_i (
        .stage  (stage_q),
        .period (period_lo)
    );

    freq_dither_period_lut #(
        .CLK_HZ   (CLK_HZ),
        .BASE_HZ  (BASE_HI_HZ),
        .PERIOD_W (PERIOD_W)
    ) lut_hi_i (
        .stage  (stage_q),
        .period (period_hi)
    );

    // Output select between the two base tables by the latched select.
    always_comb begin
        period_cycles = base_hi_q ? period_hi : period_lo;
        stage_idx     = 3'(stage_q);
    end

endmodule

// File: rtl/freq_dither_seq_chk.sv
// Module: freq_dither_seq_chk
// Property checker for freq_dither_seq, attached by bind below.
// Assumes: reset is asserted from time zero for at least one edge.
module freq_dither_seq_chk #(
    parameter int PERIOD_W = 16,
    parameter int DWELL_W  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run_en,
    input logic                period_tick,
    input logic [PERIOD_W-1:0] period_cycles,
    input logic [2:0]          stage_idx,
    input logic [DWELL_W-1:0]  tick_cnt
);

    // Stage index stays within the five-entry loop.
    assert_stage_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stage_idx <= 3'd4);

    // Disable returns the stage to the first entry on the next cycle.
    assert_disable_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (stage_idx == 3'd0) && (tick_cnt == '0));

    // A running stage change is always a single step with wrap.
    assert_step_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run_en) && stage_idx != $past(stage_idx)) |->
        stage_idx == (($past(stage_idx) == 3'd4) ? 3'd0 : $past(stage_idx) + 3'd1));

    // The stage only moves on a tick or on a disable.
    assert_step_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && stage_idx != $past(stage_idx)) |->
        ($past(period_tick) || !$past(run_en)));

    // The tick count only moves on a tick or on a disable.
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && tick_cnt != $past(tick_cnt)) |->
        ($past(period_tick) || !$past(run_en)));

    // Within a running stage the period is held steady.
    assert_period_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && run_en && $past(run_en) && stage_idx == $past(stage_idx)) |->
        $stable(period_cycles));

endmodule

bind freq_dither_seq freq_dither_seq_chk #(
    .PERIOD_W (PERIOD_W),
    .DWELL_W  (DWELL_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_en        (run_en),
    .period_tick   (period_tick),
    .period_cycles (period_cycles),
    .stage_idx     (stage_idx),
    .tick_cnt      (tick_cnt)
);

// File: tb/freq_dither_seq_tb_top.sv
// Directed bench for freq_dither_seq: one task per scenario.
module freq_dither_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       base_hi = 1'b0;
    logic       period_tick = 1'b0;
    logic [7:0] dwell_len = 8'd0;
    logic [15:0] period_cycles;
    logic [2:0]  stage_idx;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    bit reported = 1'b0;

    int exp_lo [5] = '{2222, 1818, 1905, 2000, 2105};
    int exp_hi [5] = '{1587, 1299, 1361, 1429, 1504};

    always #10 clk = ~clk;

    freq_dither_seq dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_en        (run_en),
        .base_hi       (base_hi),
        .period_tick   (period_tick),
        .dwell_len     (dwell_len),
        .period_cycles (period_cycles),
        .stage_idx     (stage_idx)
    );

    task automatic check(input int act, input int exp, input string req);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_state(input int stg, input bit hi, input string req);
        check(int'(stage_idx), stg, req);
        check(int'(period_cycles), hi ? exp_hi[stg] : exp_lo[stg], req);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) period_tick = 1'b1;
        @(negedge clk) period_tick = 1'b0;
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        end
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0; run_en = 1'b0; base_hi = 1'b0;
        idle(4);
        rst_n = 1'b1; run_en = 1'b1;
        idle(1);
        check_state(0, 1'b0, "R1");
    endtask

    // R2, R4, R5: 50 kHz loop, dwell 2, through the wrap.
    task automatic t_loop_lo();
        dwell_len = 8'd2;
        for (int k = 0; k < 10; k++) begin
            tick();
            check_state(((k + 1) / 2) % 5, 1'b0, "R2/R4/R5");
        end
    endtask

    // R9: no ticks means nothing changes.
    task automatic t_hold();
        idle(12);
        check_state(0, 1'b0, "R9");
    endtask

    // R6: dwell setting zero gives 16 periods per stage.
    task automatic t_default_dwell();
        dwell_len = 8'd0;
        for (int k = 0; k < 15; k++) tick();
        check_state(0, 1'b0, "R6");
        tick();
        check_state(1, 1'b0, "R6");
    endtask

    // R7: disable restarts, ignores ticks, clears the count.
    task automatic t_disable();
        run_en = 1'b0; idle(1); run_en = 1'b1;
        dwell_len = 8'd3;
        for (int k = 0; k < 7; k++) tick();
        check_state(2, 1'b0, "R7");
        run_en = 1'b0;
        idle(1);
        check_state(0, 1'b0, "R7");
        for (int k = 0; k < 5; k++) begin
            tick();
            check_state(0, 1'b0, "R7");
        end
        run_en = 1'b1;
        tick(); tick();
        check_state(0, 1'b0, "R7");
        tick();
        check_state(1, 1'b0, "R7");
    endtask

    // R3: 70 kHz loop, dwell 1.
    task automatic t_loop_hi();
        run_en = 1'b0; base_hi = 1'b1;
        idle(1);
        run_en = 1'b1; dwell_len = 8'd1;
        idle(1);
        check_state(0, 1'b1, "R3");
        for (int k = 0; k < 5; k++) begin
            tick();
            check_state((k + 1) % 5, 1'b1, "R3");
        end
    endtask

    // R8: base change waits for the stage boundary.
    task automatic t_sel_defer();
        dwell_len = 8'd3;
        base_hi = 1'b0;
        idle(2);
        check_state(0, 1'b1, "R8");
        tick(); tick();
        check_state(0, 1'b1, "R8");
        tick();
        check_state(1, 1'b0, "R8");
    endtask

    // R8: base change on the very tick that ends the dwell.
    task automatic t_sel_same_cycle();
        dwell_len = 8'd1;
        @(negedge clk) begin period_tick = 1'b1; base_hi = 1'b1; end
        @(negedge clk) period_tick = 1'b0;
        check_state(2, 1'b1, "R8");
    endtask

    // R10: tick together with disable; disable wins.
    task automatic t_collide();
        @(negedge clk) begin period_tick = 1'b1; run_en = 1'b0; base_hi = 1'b0; end
        @(negedge clk) period_tick = 1'b0;
        check_state(0, 1'b0, "R10");
        run_en = 1'b1;
        idle(2);
        check_state(0, 1'b0, "R10");
        tick();
        check_state(1, 1'b0, "R10");
    endtask

    initial begin
        t_reset();
        t_loop_lo();
        t_hold();
        t_default_dwell();
        t_disable();
        t_loop_hi();
        t_sel_defer();
        t_sel_same_cycle();
        t_collide();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            report();
            $finish;
        end
    end

endmodule